// File: doc/BRIEF.md
# Receiver Power-Mode Sequencer

This block sits on the host side of a radio receiver. It moves the receiver between its powered-down and active modes by issuing a fixed, ordered list of register writes. It keeps local shadow copies of two receiver registers: the power-control word and the audio-output word. Writes leave the block through a simple request/acknowledge port. The address and data stay fixed from the moment the request rises until the acknowledge arrives. The serial link that carries each write is handled elsewhere.

A powerup writes the enable bit. The block then counts a parameterised settling time, restores the active-mode audio pattern and switches data decoding on. A powerdown reverses this. Decoding goes off first, the audio word takes the requested high-impedance setting, and the disable bit is written. The block then waits for a read-back showing that the receiver has cleared both of its self-clearing bits. Finally it writes the powered-down audio pattern. While a sequence runs, the block reports busy. A request made during that time is dropped and raises a one-cycle error pulse. The block also latches the control-bus mode strap on the first clock after reset is released.

Top module: `rx_power_sequencer`

## Requirements
- R1: While reset is held and right after it, the block reports powered-down (down_o=1, busy_o=0, active_o=0). The power shadow is 0x0000 and the audio shadow is 0x0100.
- R2: A powerup request while powered down produces these steps in order:
  - a power-register write (address 2) with enable (bit 0) set and both disable (bit 6) and decode (bit 12) clear;
  - exactly SETTLE_CYCLES cycles with no write;
  - an audio-register write (address 7) whose bits 13:0 are 0x3C04;
  - a power-register write with enable and decode set.
- R3: busy_o is high from the cycle after a request is accepted until its last step completes. active_o rises only after the final powerup write is acknowledged.
- R4: Every write to the power register has the enable bit (bit 0) set.
- R5: A powerdown request while active first writes the power register with decode (bit 12) cleared. Only after that does it write the disable bit (bit 6) as 1 together with enable.
- R6: Bits 13:0 of the audio shadow read 0x0100 whenever powered down and 0x3C04 whenever active. The powerdown audio write places the high-impedance request, sampled when the powerdown is accepted, in bit 14. Bit 14 keeps that value through later writes.
- R7: After the disable write, the block waits until a valid read-back shows enable and disable both 0. It then clears those two shadow bits, writes the audio register with bits 13:0 = 0x0100, and reports powered-down.
- R8: A powerup or powerdown request made while busy has no effect on the sequence. It raises err_o for the following cycle. A request that does not fit the current mode (powerup while active, powerdown while off) is ignored without error.
- R9: bus_mode_o takes the value of bus_sel_i on the first clock after reset release. It then holds that value until the next reset.
- R10: Once wr_req_o is raised, wr_req_o, wr_addr_o and wr_data_o stay unchanged until the cycle in which wr_ack_i is seen high. A shadow register updates only on an acknowledged write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus-mode strap, latched after reset release |
| pwrup_req_i | input | 1 | Powerup request |
| pwrdn_req_i | input | 1 | Powerdown request |
| hiz_req_i | input | 1 | High-impedance audio request, sampled with a powerdown |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | 16 | Register data of the write |
| wr_ack_i | input | 1 | Write acknowledge |
| rb_valid_i | input | 1 | Read-back of power register is valid |
| rb_enable_i | input | 1 | Read-back enable bit |
| rb_disable_i | input | 1 | Read-back disable bit |
| busy_o | output | 1 | Sequence in progress |
| active_o | output | 1 | Receiver active |
| down_o | output | 1 | Receiver powered down |
| err_o | output | 1 | Request-while-busy pulse |
| bus_mode_o | output | 1 | Latched bus mode |
| pwr_shadow_o | output | 16 | Power-control register shadow |
| aud_shadow_o | output | 16 | Audio-output register shadow |

## Verification
The following properties are checked on every cycle:
- the enable bit is never written as 0;
- decode is already off in the shadow before the disable write;
- the audio low-bit patterns match the mode;
- write requests are held stable until acknowledged;
- the bus mode holds after it is latched;
- powerdown ends only after a cleared read-back.

Other properties depend on the order of events across a whole sequence, so only the bench scenarios can show them:
- the exact length of the settling gap;
- the order of the writes;
- requests dropped while busy;
- partial read-backs that must not end a powerdown;
- the high-impedance bit carried into later writes.

// File: rtl/rx_power_sequencer.sv
module rx_power_sequencer #(
  parameter int SETTLE_CYCLES = 2000,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              pwrup_req_i,
  input  logic              pwrdn_req_i,
  input  logic              hiz_req_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  input  logic              wr_ack_i,
  input  logic              rb_valid_i,
  input  logic              rb_enable_i,
  input  logic              rb_disable_i,
  output logic              busy_o,
  output logic              active_o,
  output logic              down_o,
  output logic              err_o,
  output logic              bus_mode_o,
  output logic [15:0]       pwr_shadow_o,
  output logic [15:0]       aud_shadow_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] PWR_ADDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] AUD_ADDR = ADDR_W'(7);
  localparam int EN_BIT  = 0;
  localparam int DIS_BIT = 6;
  localparam int DEC_BIT = 12;
  localparam logic [13:0] ON_PAT  = 14'h3C04;
  localparam logic [13:0] OFF_PAT = 14'h0100;

  typedef enum logic [3:0] {
    S_OFF, S_UP_EN, S_UP_WAIT, S_UP_AUD, S_UP_DEC, S_ON,
    S_DN_DEC, S_DN_AUD, S_DN_DIS, S_DN_RB, S_DN_AUD2
  } st_t;

  st_t st, nx;
  logic [CW-1:0] cnt;
  logic [15:0] pwr_q, aud_q, pwr_base;
  logic hiz_q, latched, bus_q, err_q;

  wire rb_clear = rb_valid_i && !rb_enable_i && !rb_disable_i;
  wire ack      = wr_req_o && wr_ack_i;

  assign busy_o       = (st != S_OFF) && (st != S_ON);
  assign active_o     = (st == S_ON);
  assign down_o       = (st == S_OFF);
  assign err_o        = err_q;
  assign bus_mode_o   = bus_q;
  assign pwr_shadow_o = pwr_q;
  assign aud_shadow_o = aud_q;

  always_comb begin
    nx = st;
    case (st)
      S_OFF:     if (pwrup_req_i) nx = S_UP_EN;
      S_UP_EN:   if (ack) nx = S_UP_WAIT;
      S_UP_WAIT: if (cnt == CW'(SETTLE_CYCLES - 1)) nx = S_UP_AUD;
      S_UP_AUD:  if (ack) nx = S_UP_DEC;
      S_UP_DEC:  if (ack) nx = S_ON;
      S_ON:      if (pwrdn_req_i) nx = S_DN_DEC;
      S_DN_DEC:  if (ack) nx = S_DN_AUD;
      S_DN_AUD:  if (ack) nx = S_DN_DIS;
      S_DN_DIS:  if (ack) nx = S_DN_RB;
      S_DN_RB:   if (rb_clear) nx = S_DN_AUD2;
      S_DN_AUD2: if (ack) nx = S_OFF;
      default:   nx = S_OFF;
    endcase
  end

  always_comb begin
    pwr_base          = pwr_q;
    pwr_base[EN_BIT]  = 1'b1;
    pwr_base[DIS_BIT] = 1'b0;
    pwr_base[DEC_BIT] = 1'b0;
    wr_req_o  = 1'b1;
    wr_addr_o = PWR_ADDR;
    wr_data_o = pwr_base;
    case (st)
      S_UP_EN, S_DN_DEC: wr_data_o = pwr_base;
      S_UP_DEC: wr_data_o = pwr_base | (16'd1 << DEC_BIT);
      S_DN_DIS: wr_data_o = pwr_base | (16'd1 << DIS_BIT);
      S_UP_AUD: begin
        wr_addr_o = AUD_ADDR;
        wr_data_o = {aud_q[15:14], ON_PAT};
      end
      S_DN_AUD: begin
        wr_addr_o = AUD_ADDR;
        wr_data_o = {aud_q[15], hiz_q, ON_PAT};
      end
      S_DN_AUD2: begin
        wr_addr_o = AUD_ADDR;
        wr_data_o = {aud_q[15:14], OFF_PAT};
      end
      default: begin
        wr_req_o  = 1'b0;
        wr_data_o = 16'h0000;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      pwr_q   <= 16'h0000;
      aud_q   <= {2'b00, OFF_PAT};
      hiz_q   <= 1'b0;
      err_q   <= 1'b0;
      latched <= 1'b0;
      bus_q   <= 1'b0;
    end else begin
      st    <= nx;
      err_q <= busy_o && (pwrup_req_i || pwrdn_req_i);
      cnt   <= (st == S_UP_WAIT) ? cnt + 1'b1 : '0;
      if (st == S_ON && pwrdn_req_i) hiz_q <= hiz_req_i;
      if (!latched) begin
        latched <= 1'b1;
        bus_q   <= bus_sel_i;
      end
      if (ack) begin
        if (wr_addr_o == PWR_ADDR) pwr_q <= wr_data_o;
        else aud_q <= wr_data_o;
      end else if (st == S_DN_RB && rb_clear) begin
        pwr_q[EN_BIT]  <= 1'b0;
        pwr_q[DIS_BIT] <= 1'b0;
      end
    end
  end

  assert_enable_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_addr_o == PWR_ADDR) |-> wr_data_o[EN_BIT]);

  assert_decode_off_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_addr_o == PWR_ADDR && wr_data_o[DIS_BIT]) |-> !pwr_q[DEC_BIT]);

  assert_audio_off_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    down_o |-> aud_q[13:0] == OFF_PAT);

  assert_audio_on_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> aud_q[13:0] == ON_PAT);

  assert_readback_before_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DN_DIS && ack) |=> !down_o && !active_o);

  assert_err_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && pwrup_req_i) |=> err_o);

  assert_bus_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(bus_q));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_active_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(wr_ack_i));
endmodule

// File: tb/sim_rx_power_sequencer.sv
module sim_rx_power_sequencer;
  localparam int SETTLE = 12;
  localparam logic [15:0] EN = 16'h0001, DIS = 16'h0040, DEC = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b1, up = 1'b0, dn = 1'b0, hiz = 1'b0;
  logic wr_req, wr_ack = 1'b0;
  logic [3:0] wr_addr;
  logic [15:0] wr_data, pwr_sh, aud_sh;
  logic rb_valid = 1'b0, rb_en = 1'b0, rb_dis = 1'b0;
  logic busy, active, down, err, bus_mode;

  int checks = 0, fails = 0, ack_lat = 0, lat_cnt = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_power_sequencer #(.SETTLE_CYCLES(SETTLE), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .pwrup_req_i(up),
    .pwrdn_req_i(dn), .hiz_req_i(hiz), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_ack_i(wr_ack), .rb_valid_i(rb_valid),
    .rb_enable_i(rb_en), .rb_disable_i(rb_dis), .busy_o(busy),
    .active_o(active), .down_o(down), .err_o(err), .bus_mode_o(bus_mode),
    .pwr_shadow_o(pwr_sh), .aud_shadow_o(aud_sh));

  // reference model: queue of pending steps, kind in [31:30] (0 write, 1 settle, 2 read-back)
  logic [31:0] mq[$];
  logic m_on, m_dir, m_err, m_bus, m_latched;
  logic [15:0] m_pwr, m_aud;
  int m_wait;

  function automatic logic [31:0] wr_step(input logic [3:0] a, input logic [15:0] d);
    return {2'b00, 10'd0, a, d};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_on = 0; m_dir = 0; m_err = 0; m_bus = 0; m_latched = 0;
      m_pwr = 16'h0000; m_aud = 16'h0100; m_wait = 0;
    end else begin
      automatic bit busy_pre = (mq.size() != 0);
      automatic bit popped = 0;
      m_err = busy_pre && (up || dn);
      if (!m_latched) begin m_bus = bus_sel; m_latched = 1; end
      if (busy_pre) begin
        automatic logic [31:0] h = mq[0];
        case (h[31:30])
          2'd0: if (wr_ack) begin
            if (h[19:16] == 4'd2) m_pwr = h[15:0]; else m_aud = h[15:0];
            popped = 1;
          end
          2'd1: begin
            m_wait++;
            if (m_wait == SETTLE) begin popped = 1; m_wait = 0; end
          end
          default: if (rb_valid && !rb_en && !rb_dis) begin
            m_pwr = m_pwr & ~(EN | DIS);
            popped = 1;
          end
        endcase
        if (popped) begin
          void'(mq.pop_front());
          if (mq.size() == 0) m_on = m_dir;
        end
      end else if (!m_on && up) begin
        automatic logic [15:0] b = (m_pwr & ~(DIS | DEC)) | EN;
        mq.push_back(wr_step(4'd2, b));
        mq.push_back({2'b01, 30'd0});
        mq.push_back(wr_step(4'd7, {m_aud[15:14], 14'h3C04}));
        mq.push_back(wr_step(4'd2, b | DEC));
        m_dir = 1;
      end else if (m_on && dn) begin
        automatic logic [15:0] b = (m_pwr & ~(DIS | DEC)) | EN;
        mq.push_back(wr_step(4'd2, b));
        mq.push_back(wr_step(4'd7, {m_aud[15], hiz, 14'h3C04}));
        mq.push_back(wr_step(4'd2, b | DIS));
        mq.push_back({2'b10, 30'd0});
        mq.push_back(wr_step(4'd7, {m_aud[15], hiz, 14'h0100}));
        m_dir = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      automatic bit mb = (mq.size() != 0);
      automatic bit mw = mb && (mq[0][31:30] == 2'd0);
      cyc++;
      chk("R1/R3 busy", busy, mb);
      chk("R3 active", active, m_on && !mb);
      chk("R1/R7 down", down, !m_on && !mb);
      chk("R8 err", err, m_err);
      chk("R2/R10 wr_req", wr_req, mw);
      if (mw) begin
        chk("R2/R5 wr_addr", wr_addr, mq[0][19:16]);
        chk("R4/R5/R6 wr_data", wr_data, mq[0][15:0]);
      end
      chk("R7/R10 pwr shadow", pwr_sh, m_pwr);
      chk("R6 aud shadow", aud_sh, m_aud);
      chk("R9 bus mode", bus_mode, m_bus);
    end
  end

  // acknowledge driver with programmable latency
  always @(negedge clk) begin
    if (wr_req && !wr_ack) begin
      if (lat_cnt >= ack_lat) begin wr_ack <= 1'b1; lat_cnt <= 0; end
      else lat_cnt <= lat_cnt + 1;
    end else begin
      wr_ack <= 1'b0; lat_cnt <= 0;
    end
  end

  task automatic pulse(input bit u, input bit d);
    @(negedge clk); up = u; dn = d;
    @(negedge clk); up = 0; dn = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readback_done();
    while (!(mq.size() != 0 && mq[0][31:30] == 2'd2)) @(negedge clk);
    rb_valid = 1; rb_en = 1; rb_dis = 1;
    repeat (2) @(negedge clk);
    rb_en = 0;
    @(negedge clk);
    rb_en = 1; rb_dis = 0;
    @(negedge clk);
    rb_en = 0; rb_dis = 0;
    @(negedge clk);
    rb_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;                           // R1 reset state, R9 latch of 1
    @(negedge clk); bus_sel = 0;         // R9 must hold
    repeat (2) @(negedge clk);
    pulse(0, 1);                         // R8 powerdown while off: ignored
    ack_lat = 0;
    pulse(1, 0);                         // R2 powerup, zero-latency ack
    repeat (3) @(negedge clk);
    pulse(0, 1);                         // R8 request while busy
    pulse(1, 0);
    wait_idle();
    pulse(1, 0);                         // R8 powerup while active: ignored
    rb_valid = 1; @(negedge clk); rb_valid = 0;   // read-back outside wait ignored
    ack_lat = 3; hiz = 1;
    pulse(0, 1);                         // R5/R6/R7 powerdown with high-Z
    hiz = 0;
    readback_done();
    wait_idle();
    ack_lat = 1;
    pulse(1, 0);                         // R6 bit 14 kept across powerup
    wait_idle();
    pulse(0, 1);
    readback_done();
    wait_idle();
    @(negedge clk); rst_n = 0;           // R9 relatch with 0
    @(negedge clk); bus_sel = 0; rst_n = 1;
    @(negedge clk); bus_sel = 1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule